// File: doc/BRIEF.md
# Serial-Write Mapper Register Loader

This block sits on the cartridge side of a CPU bus. The bus has a phase-2 clock (`m2`), a read/write line and an active-low ROM-select strobe. The block watches that bus for writes into ROM space. Each qualifying write moves data bit 0 into a small shift register. After five such writes, the four bits already held and the fifth write's bit 0 are loaded as one 5-bit value into one of four internal registers. The bus inputs are asynchronous to the block. Each one passes through a two-flop synchronizer to the fast system clock `clk`, and edges are then detected in that clock domain.

A write is recognised when `m2` falls. A run of write cycles that follow one another directly produces only one shift. The detector arms again only after a read cycle or a cycle with ROM select inactive. A ROM-space write with data bit 7 set restarts the sequence. It clears only the write counter and leaves the held shift bits in place. In the same cycle it forces bits 3:2 of register 0, the control register, to ones.

Top module: `serialLoader`

## Requirements
- R1: After reset, `regOut0` is 5'h0C and `regOut1`, `regOut2` and `regOut3` are 5'h00.
- R2: A cycle counts as a write only when `busRw` is 0 and `romSelN` is 0 as `m2` falls. A read cycle, or a write cycle with `romSelN` at 1, neither shifts nor advances the load sequence.
- R3: Five counted writes complete a load. The loaded value takes bit 0 from the first write's D0, up to bit 4 from the fifth write's D0. The sequence then starts over.
- R4: On the fifth write, `busAddr` selects the target register: 0 selects `regOut0`, 1 `regOut1`, 2 `regOut2` and 3 `regOut3`.
- R5: When a write cycle follows another write cycle to ROM space directly, the second one is not counted and its D0 is discarded.
- R6: After a read cycle or a cycle with `romSelN` at 1, the next ROM-space write is counted again.
- R7: A ROM-space write with `busD7` at 1 clears the write count. It is not counted itself, and it leaves the held shift bits unchanged. Exactly five further counted writes are then needed for a load.
- R8: A ROM-space write with `busD7` at 1 sets bits 3:2 of `regOut0` and leaves its bits 4, 1 and 0 unchanged.
- R9: The register outputs change only because of a load or a bit-7 write. The change appears within three `clk` edges after `m2` falls at the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| m2 | input | 1 | Bus phase-2 clock, asynchronous |
| busRw | input | 1 | 1 = read, 0 = write |
| romSelN | input | 1 | ROM-space select, active low |
| busAddr | input | 2 | CPU address bits 14:13, selects the register on a load |
| busD0 | input | 1 | Serial data bit |
| busD7 | input | 1 | Sequence-reset data bit |
| regOut0 | output | 5 | Control register |
| regOut1 | output | 5 | Register 1 |
| regOut2 | output | 5 | Register 2 |
| regOut3 | output | 5 | Register 3 |

## Verification
Bus inputs pass through two synchronizer flops and one edge-history flop. A fall of `m2` that the bench drives between clock edges therefore changes a register output on the third following `clk` edge. The bench holds each bus phase for six clocks, so every comparison falls at least three edges after the change is due. It compares all four outputs once per bus cycle, after the low phase ends. Expected values come from a per-bus-cycle model: a counted write, a suppressed write and a bit-7 write each take effect at the end of the bus cycle in which they occur.

// File: rtl/serialLoaderPkg.sv
package serialLoaderPkg;
  localparam int REG_W     = 5;
  localparam int NUM_REGS  = 4;
  localparam int SEL_W     = $clog2(NUM_REGS);
  localparam int WRITES    = REG_W;
  localparam int CNT_W     = $clog2(WRITES);
  localparam int HELD_W    = REG_W - 1;
  localparam logic [REG_W-1:0] CTRL_INIT  = 5'h0C;
  localparam logic [REG_W-1:0] CTRL_FORCE = 5'h0C;

  typedef struct packed {
    logic             shiftEn;
    logic             commit;
    logic             seqReset;
    logic             dataBit;
    logic [SEL_W-1:0] sel;
  } ldStrobe_t;
endpackage

// File: rtl/serialLoaderCtrl.sv
module serialLoaderCtrl
  import serialLoaderPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             m2,
  input  logic             busRw,
  input  logic             romSelN,
  input  logic [SEL_W-1:0] busAddr,
  input  logic             busD0,
  input  logic             busD7,
  output ldStrobe_t        strobe
);
  localparam int IN_W = 5 + SEL_W;
  localparam logic [IN_W-1:0] IDLE_IN = {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, {SEL_W{1'b0}}};
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WRITES - 1);

  logic [IN_W-1:0] rawIn;
  logic [IN_W-1:0] syncQ [SYNC_STAGES];

  assign rawIn = {m2, busRw, romSelN, busD7, busD0, busAddr};

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= IDLE_IN;
        else       syncQ[s] <= rawIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= IDLE_IN;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  end

  logic             m2S, rwS, romSelNS, d7S, d0S;
  logic [SEL_W-1:0] addrS;
  assign {m2S, rwS, romSelNS, d7S, d0S, addrS} = syncQ[SYNC_STAGES-1];

  logic             m2Prev;
  logic             wrReq;
  logic [CNT_W-1:0] wrCount;
  logic             m2Fall, newReq, resetHit, shiftHit, commitHit;

  assign m2Fall    = m2Prev & ~m2S;
  assign newReq    = ~rwS & ~romSelNS;
  assign resetHit  = m2Fall & newReq & d7S;
  // Rising edge of the latched request, seen while m2 is low.
  assign shiftHit  = m2Fall & newReq & ~wrReq & ~d7S;
  assign commitHit = shiftHit & (wrCount == LAST_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m2Prev  <= 1'b0;
      wrReq   <= 1'b0;
      wrCount <= '0;
    end else begin
      m2Prev <= m2S;
      if (m2Fall) wrReq <= newReq;
      if (resetHit)       wrCount <= '0;
      else if (commitHit) wrCount <= '0;
      else if (shiftHit)  wrCount <= wrCount + 1'b1;
    end
  end

  always_comb begin
    strobe.shiftEn  = shiftHit;
    strobe.commit   = commitHit;
    strobe.seqReset = resetHit;
    strobe.dataBit  = d0S;
    strobe.sel      = addrS;
  end
endmodule

// File: rtl/serialLoaderData.sv
module serialLoaderData
  import serialLoaderPkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  ldStrobe_t                       strobe,
  output logic [NUM_REGS-1:0][REG_W-1:0]  regBank
);
  logic [HELD_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {strobe.dataBit, shiftReg[HELD_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++)
        regBank[i] <= (i == 0) ? CTRL_INIT : '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (strobe.commit && strobe.sel == SEL_W'(i))
          regBank[i] <= {strobe.dataBit, shiftReg};
        else if (i == 0 && strobe.seqReset)
          regBank[i] <= regBank[i] | CTRL_FORCE;
      end
    end
  end
endmodule

// File: rtl/serialLoader.sv
module serialLoader
  import serialLoaderPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             m2,
  input  logic             busRw,
  input  logic             romSelN,
  input  logic [SEL_W-1:0] busAddr,
  input  logic             busD0,
  input  logic             busD7,
  output logic [REG_W-1:0] regOut0,
  output logic [REG_W-1:0] regOut1,
  output logic [REG_W-1:0] regOut2,
  output logic [REG_W-1:0] regOut3
);
  ldStrobe_t                      ctlStrobe;
  logic [NUM_REGS-1:0][REG_W-1:0] regBank;

  serialLoaderCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .m2(m2), .busRw(busRw), .romSelN(romSelN),
    .busAddr(busAddr), .busD0(busD0), .busD7(busD7), .strobe(ctlStrobe)
  );

  serialLoaderData u_data (
    .clk(clk), .rstN(rstN), .strobe(ctlStrobe), .regBank(regBank)
  );

  assign regOut0 = regBank[0];
  assign regOut1 = regBank[1];
  assign regOut2 = regBank[2];
  assign regOut3 = regBank[3];
endmodule

// File: rtl/serialLoaderChk.sv
module serialLoaderChk
  import serialLoaderPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input ldStrobe_t         strobe,
  input logic [REG_W-1:0]  r0,
  input logic [REG_W-1:0]  r1,
  input logic [REG_W-1:0]  r2,
  input logic [REG_W-1:0]  r3,
  input logic [HELD_W-1:0] heldBits
);
  // R3: a load only happens on a counted write
  a_r3_commit_on_shift: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> strobe.shiftEn);
  // R7: a bit-7 write is never counted
  a_r7_reset_not_counted: assert property (@(posedge clk) disable iff (!rstN)
    strobe.seqReset |-> !strobe.shiftEn);
  // R7: held bits survive a bit-7 write
  a_r7_held_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobe.seqReset |=> $stable(heldBits));
  // R8: control mode bits forced high
  a_r8_ctrl_forced: assert property (@(posedge clk) disable iff (!rstN)
    strobe.seqReset |=> (r0[3:2] == 2'b11));
  // R5: one bus cycle gives at most one shift event
  a_r5_single_event: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> !strobe.shiftEn);
  // R9: outputs quiet without load or bit-7 write
  a_r9_regs_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.commit && !strobe.seqReset) |=> $stable({r0, r1, r2, r3}));
endmodule

bind serialLoader serialLoaderChk u_chk (
  .clk(clk), .rstN(rstN), .strobe(ctlStrobe),
  .r0(regOut0), .r1(regOut1), .r2(regOut2), .r3(regOut3),
  .heldBits(u_data.shiftReg)
);

// File: tb/serialLoader_bench.sv
`timescale 1ns/1ps
module serialLoader_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       m2 = 1'b0, busRw = 1'b1, romSelN = 1'b1, busD0 = 1'b0, busD7 = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [4:0] regOut0, regOut1, regOut2, regOut3;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  serialLoader u_serialLoader (
    .clk(clk), .rstN(rstN), .m2(m2), .busRw(busRw), .romSelN(romSelN),
    .busAddr(busAddr), .busD0(busD0), .busD7(busD7),
    .regOut0(regOut0), .regOut1(regOut1), .regOut2(regOut2), .regOut3(regOut3)
  );

  // reference model, one step per bus cycle
  logic [4:0] mRegs [4];
  logic [3:0] mShift;
  int         mCnt;
  logic       mPrev;

  function automatic logic [4:0] dutReg(int idx);
    case (idx)
      0: return regOut0;
      1: return regOut1;
      2: return regOut2;
      default: return regOut3;
    endcase
  endfunction

  function automatic logic [4:0] orCtrl(logic [4:0] v);
    return v | 5'h0C;
  endfunction

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    for (int i = 0; i < 4; i++) check(tag, dutReg(i), mRegs[i]);
  endtask

  task automatic modelStep(logic rw, logic rs, logic [1:0] a, logic [7:0] d);
    logic nr;
    nr = !rw && !rs;
    if (nr && d[7]) begin
      mCnt = 0;
      mRegs[0] = orCtrl(mRegs[0]);
    end else if (nr && !mPrev) begin
      if (mCnt == 4) begin
        mRegs[a] = {d[0], mShift};
        mCnt = 0;
      end else mCnt++;
      mShift = {d[0], mShift[3:1]};
    end
    mPrev = nr;
  endtask

  task automatic busCycle(logic rw, logic rs, logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    busRw = rw; romSelN = rs; busAddr = a; busD0 = d[0]; busD7 = d[7]; m2 = 1'b1;
    repeat (6) @(negedge clk);
    m2 = 1'b0;
    repeat (6) @(negedge clk);
    modelStep(rw, rs, a, d);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);  busCycle(1'b0, 1'b0, a, d); endtask
  task automatic rd();                               busCycle(1'b1, 1'b0, 2'd0, 8'h00); endtask
  task automatic offWr(logic [7:0] d);               busCycle(1'b0, 1'b1, 2'd0, d); endtask

  task automatic loadSerial(logic [1:0] a, logic [4:0] v);
    for (int i = 0; i < 5; i++) begin
      wr(a, {7'd0, v[i]});
      rd();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    mRegs[0] = 5'h0C; mRegs[1] = 0; mRegs[2] = 0; mRegs[3] = 0;
    mShift = 0; mCnt = 0; mPrev = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset values
    check("R1 reg0", regOut0, 5'h0C);
    check("R1 reg1", regOut1, 5'h00);
    check("R1 reg2", regOut2, 5'h00);
    check("R1 reg3", regOut3, 5'h00);

    // R3 R4 plain load, LSB first
    loadSerial(2'd1, 5'b01101);
    check("R3 R4 reg1 load", regOut1, 5'b01101);
    loadSerial(2'd2, 5'b10110);
    check("R4 reg2 load", regOut2, 5'b10110);
    check("R4 reg1 untouched", regOut1, 5'b01101);

    // R2 R6: reads and ROM-inactive writes are not counted, and re-arm
    wr(2'd3, 8'h01); offWr(8'h00);
    wr(2'd3, 8'h00); rd(); rd();
    wr(2'd3, 8'h01); offWr(8'h01);
    wr(2'd3, 8'h01); offWr(8'h00);
    check("R2 no early load", regOut3, 5'h00);
    wr(2'd3, 8'h00); rd();
    check("R2 R6 reg3 load", regOut3, 5'b01101);

    // R5 back-to-back write discarded
    wr(2'd1, 8'h01); wr(2'd1, 8'h00); rd();
    wr(2'd1, 8'h01); rd();
    wr(2'd1, 8'h00); wr(2'd1, 8'h01); wr(2'd1, 8'h01); rd();
    wr(2'd1, 8'h00); rd();
    check("R5 partial after doubles", regOut1, 5'b01101);
    wr(2'd1, 8'h01); rd();
    check("R5 reg1 load", regOut1, 5'b10011);

    // R7 bit-7 write mid sequence restarts count
    wr(2'd2, 8'h01); rd(); wr(2'd2, 8'h00); rd();
    wr(2'd2, 8'h81); rd();
    for (int i = 0; i < 4; i++) begin wr(2'd2, {7'd0, i[0]}); rd(); end
    check("R7 no load after four", regOut2, 5'b10110);
    wr(2'd2, 8'h01); rd();
    check("R7 reg2 load", regOut2, 5'b11010);

    // R8 control forcing
    loadSerial(2'd0, 5'b10011);
    check("R8 reg0 loaded", regOut0, 5'b10011);
    wr(2'd0, 8'h80); rd();
    check("R8 reg0 forced", regOut0, 5'b11111);
    loadSerial(2'd0, 5'b00000);
    wr(2'd0, 8'hFF); rd();
    check("R8 reg0 from zero", regOut0, 5'h0C);
    check("R8 reg1 untouched", regOut1, 5'b10011);

    // R9 random mix against model
    for (int n = 0; n < 400; n++) begin
      int k;
      logic [7:0] d;
      k = $urandom % 8;
      d = {($urandom % 12) == 0, 6'd0, 1'($urandom)};
      case (k)
        0, 1, 2, 3, 6: wr(2'($urandom), d);
        5:             offWr(d);
        default:       rd();
      endcase
      compareAll("R9 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule